// File: doc/BRIEF.md
# Low-Frequency Timebase and Tick Interrupt Generator

This block runs on a 32768 Hz reference clock, coming from either a crystal or an RC oscillator, and divides it into periodic ticks for a small microcontroller. A 15-bit synchronous counter provides four taps. The fast interrupt tick runs at 2048 Hz. The LCD scan tick runs at 512 Hz. The middle interrupt tick runs at 128 Hz. The slow tick runs at 2 Hz and also serves as the standby wake-up source. Each tick is a single-cycle pulse. It is produced in the cycle where the counter shows that its tap bit has just risen.

Three of the ticks (fast, middle, slow) can each raise a sticky request flag when their enable bit is set. Software clears a flag by pulsing its clear strobe.

The block also sequences the crystal drive strength after reset. The drive stays strong for four seconds, which is eight slow ticks, and then stays weak until the next reset. An oscillator-enable output follows a stop request one cycle later. While the oscillator is disabled, the divider holds its value and no tick is produced.

Top module: `lf_timebase`

## Requirements
- R1: While reset is asserted, all tick outputs and request flags are 0, `drive_strong_o` is 1 and `osc_en_o` is 1; the counter restarts from 0.
- R2: Counting the advancing clock edges after reset as n, `tick_fast_o` is high for exactly the cycles where n mod 16 equals 8 (counter bit 3 has just risen).
- R3: `tick_lcd_o` is high exactly when n mod 64 equals 32 (bit 5).
- R4: `tick_mid_o` is high exactly when n mod 256 equals 128 (bit 7).
- R5: `tick_slow_o` is high exactly when n mod 16384 equals 8192 (bit 13, 2 Hz).
- R6: Every tick lasts one cycle, and no two ticks are ever high in the same cycle.
- R7: `osc_en_o` equals the inverse of `osc_stop_i` sampled one edge earlier. An edge at which `osc_en_o` is 0 does not advance the counter and produces no tick.
- R8: The request bit order is 0 = fast, 1 = middle, 2 = slow. A tick sets its flag at the next edge only if its `irq_en_i` bit is 1. A flag whose enable bit is 0 stays 0. A set flag stays set.
- R9: A 1 on an `irq_clr_i` bit clears that flag at the next edge, and the clear wins over a set in the same cycle.
- R10: `drive_strong_o` falls at the edge after the eighth slow tick following reset and stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf_i | input | 1 | 32768 Hz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_stop_i | input | 1 | Request to stop the oscillator |
| irq_en_i | input | 3 | Per-source request enables (0 fast, 1 middle, 2 slow) |
| irq_clr_i | input | 3 | Write-one-to-clear strobes for the flags |
| tick_fast_o | output | 1 | 2048 Hz tick pulse |
| tick_lcd_o | output | 1 | 512 Hz LCD scan tick pulse |
| tick_mid_o | output | 1 | 128 Hz tick pulse |
| tick_slow_o | output | 1 | 2 Hz tick pulse, also the wake-up source |
| irq_flag_o | output | 3 | Sticky request flags |
| drive_strong_o | output | 1 | 1 selects strong crystal drive |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
Some rules are checked by the assertions on every cycle: ticks are single-cycle and mutually exclusive, the counter is frozen while the oscillator is off, clear wins over set, flags rise only after an enabled tick, and weak drive is never undone. The assertions cannot show the absolute tap periods and phases, the exact cycle in which the drive drops, or the counter resuming from its held value after a stop. The bench scenarios show those by comparing every cycle against an edge-counting model over the full strong-drive interval.

// File: rtl/lf_timebase_pkg.sv
package lf_timebase_pkg;

  localparam int unsigned NTAP = 4;
  localparam int unsigned NREQ = 3;

  typedef enum logic [1:0] {
    TAP_FAST = 2'd0,
    TAP_LCD  = 2'd1,
    TAP_MID  = 2'd2,
    TAP_SLOW = 2'd3
  } tap_e;

  // True when the next increment turns bit k from 0 to 1.
  function automatic logic bit_rises(input logic [31:0] c, input int unsigned k);
    logic [31:0] low_mask;
    low_mask = (32'd1 << k) - 32'd1;
    return (c[k] == 1'b0) && ((c & low_mask) == low_mask);
  endfunction

  // True when the tick being counted is the last of the strong interval.
  function automatic logic strong_done(input int unsigned seen, input int unsigned total);
    return (seen + 1) >= total;
  endfunction

endpackage

// File: rtl/lf_divider.sv
module lf_divider
  import lf_timebase_pkg::*;
#(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned FAST_BIT = 3,
  parameter int unsigned LCD_BIT  = 5,
  parameter int unsigned MID_BIT  = 7,
  parameter int unsigned SLOW_BIT = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [NTAP-1:0] tick_o
);

  localparam int unsigned TAP_BIT [NTAP] = '{FAST_BIT, LCD_BIT, MID_BIT, SLOW_BIT};

  logic [CNT_W-1:0] cnt_q;
  logic [NTAP-1:0]  tick_q;
  logic [NTAP-1:0]  rise_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign rise_next[g] = run_i && bit_rises(32'(cnt_q), TAP_BIT[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_q[g] <= 1'b0;
      else         tick_q[g] <= rise_next[g];
    end

    assert_tick_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_q[g] |=> !tick_q[g]);
  end

  assign tick_o = tick_q;

  assert_hold_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q) && (tick_q == '0));

  assert_ticks_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tick_q));

endmodule

// File: rtl/lf_drive_seq.sv
module lf_drive_seq
  import lf_timebase_pkg::*;
#(
  parameter int unsigned STRONG_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_stop_i,
  input  logic tick_slow_i,
  output logic drive_strong_o,
  output logic osc_en_o
);

  localparam int unsigned SW = $clog2(STRONG_TICKS + 1);

  logic [SW-1:0] seen_q;
  logic          strong_q;
  logic          osc_en_q;
  logic          last_tick;

  assign last_tick = strong_done(32'(seen_q), STRONG_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= '0;
      strong_q <= 1'b1;
    end else if (strong_q && tick_slow_i) begin
      seen_q <= seen_q + SW'(1);
      if (last_tick) strong_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_en_q <= 1'b1;
    else         osc_en_q <= !osc_stop_i;
  end

  assign drive_strong_o = strong_q;
  assign osc_en_o       = osc_en_q;

  assert_weak_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strong_q |=> !strong_q);

  assert_weak_after_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strong_q) |-> $past(tick_slow_i));

  assert_osc_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (osc_en_q == !$past(osc_stop_i)));

endmodule

// File: rtl/lf_irq_flags.sv
module lf_irq_flags
  import lf_timebase_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] tick_i,
  input  logic [NREQ-1:0] en_i,
  input  logic [NREQ-1:0] clr_i,
  output logic [NREQ-1:0] flag_o
);

  logic [NREQ-1:0] flag_q;
  logic [NREQ-1:0] set_req;

  for (genvar g = 0; g < NREQ; g++) begin : g_flag
    assign set_req[g] = tick_i[g] && en_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[g] <= 1'b0;
      else if (clr_i[g])   flag_q[g] <= 1'b0;
      else if (set_req[g]) flag_q[g] <= 1'b1;
    end

    assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |=> !flag_q[g]);

    assert_enabled_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[g] && en_i[g] && !clr_i[g]) |=> flag_q[g]);

    assert_no_stray_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[g]) |-> $past(tick_i[g] && en_i[g]));
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/lf_timebase.sv
module lf_timebase
  import lf_timebase_pkg::*;
#(
  parameter int unsigned CNT_W        = 15,
  parameter int unsigned FAST_BIT     = 3,
  parameter int unsigned LCD_BIT      = 5,
  parameter int unsigned MID_BIT      = 7,
  parameter int unsigned SLOW_BIT     = 13,
  parameter int unsigned STRONG_TICKS = 8
) (
  input  logic       clk_lf_i,
  input  logic       rst_ni,
  input  logic       osc_stop_i,
  input  logic [2:0] irq_en_i,
  input  logic [2:0] irq_clr_i,
  output logic       tick_fast_o,
  output logic       tick_lcd_o,
  output logic       tick_mid_o,
  output logic       tick_slow_o,
  output logic [2:0] irq_flag_o,
  output logic       drive_strong_o,
  output logic       osc_en_o
);

  logic [NTAP-1:0] tick;
  logic [NREQ-1:0] req_tick;
  logic            osc_run;

  lf_drive_seq #(
    .STRONG_TICKS(STRONG_TICKS)
  ) u_seq (
    .clk_i         (clk_lf_i),
    .rst_ni        (rst_ni),
    .osc_stop_i    (osc_stop_i),
    .tick_slow_i   (tick[TAP_SLOW]),
    .drive_strong_o(drive_strong_o),
    .osc_en_o      (osc_run)
  );

  lf_divider #(
    .CNT_W   (CNT_W),
    .FAST_BIT(FAST_BIT),
    .LCD_BIT (LCD_BIT),
    .MID_BIT (MID_BIT),
    .SLOW_BIT(SLOW_BIT)
  ) u_div (
    .clk_i (clk_lf_i),
    .rst_ni(rst_ni),
    .run_i (osc_run),
    .tick_o(tick)
  );

  assign req_tick = {tick[TAP_SLOW], tick[TAP_MID], tick[TAP_FAST]};

  lf_irq_flags u_flags (
    .clk_i (clk_lf_i),
    .rst_ni(rst_ni),
    .tick_i(req_tick),
    .en_i  (irq_en_i),
    .clr_i (irq_clr_i),
    .flag_o(irq_flag_o)
  );

  assign tick_fast_o = tick[TAP_FAST];
  assign tick_lcd_o  = tick[TAP_LCD];
  assign tick_mid_o  = tick[TAP_MID];
  assign tick_slow_o = tick[TAP_SLOW];
  assign osc_en_o    = osc_run;

endmodule

// File: tb/lf_timebase_tb.sv
module lf_timebase_tb;

  localparam int unsigned TAP_BIT [4] = '{3, 5, 7, 13};
  localparam string       TAP_TAG [4] = '{"R2", "R3", "R4", "R5"};
  localparam int unsigned STRONG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_stop = 1'b0;
  logic [2:0] irq_en = 3'b101;
  logic [2:0] irq_clr = 3'b000;
  logic       t_fast, t_lcd, t_mid, t_slow, drv, osc_en;
  logic [2:0] flags;

  always #2 clk = ~clk;

  lf_timebase u_dut (
    .clk_lf_i      (clk),
    .rst_ni        (rst_n),
    .osc_stop_i    (osc_stop),
    .irq_en_i      (irq_en),
    .irq_clr_i     (irq_clr),
    .tick_fast_o   (t_fast),
    .tick_lcd_o    (t_lcd),
    .tick_mid_o    (t_mid),
    .tick_slow_o   (t_slow),
    .irq_flag_o    (flags),
    .drive_strong_o(drv),
    .osc_en_o      (osc_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  longint n_adv = 0;
  bit     osc_m = 1;
  bit [3:0] tick_m = '0;
  bit [2:0] flag_m = '0;
  bit     drv_m = 1;
  int     slow_seen = 0;

  // per-category mismatch tracking: 0..3 taps, 4 exclusivity, 5 osc, 6 flags, 7 drive
  int     mis [8];
  longint mis_act [8];
  longint mis_exp [8];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic note(input int c, input longint act, input longint exp);
    if (act != exp) begin
      if (mis[c] == 0) begin
        mis_act[c] = act;
        mis_exp[c] = exp;
      end
      mis[c]++;
    end
  endtask

  task automatic step();
    bit [3:0] tprev;
    @(posedge clk);
    tprev = tick_m;
    for (int i = 0; i < 3; i++) begin
      int src;
      src = (i == 0) ? 0 : (i == 1) ? 2 : 3;
      if (irq_clr[i])                   flag_m[i] = 1'b0;
      else if (tprev[src] && irq_en[i]) flag_m[i] = 1'b1;
    end
    if (drv_m && tprev[3]) begin
      slow_seen++;
      if (slow_seen >= STRONG) drv_m = 1'b0;
    end
    tick_m = '0;
    if (osc_m) begin
      n_adv++;
      for (int k = 0; k < 4; k++) begin
        longint per;
        per = longint'(2) << TAP_BIT[k];
        tick_m[k] = ((n_adv % per) == (per >> 1));
      end
    end
    osc_m = !osc_stop;
    @(negedge clk);
    for (int k = 0; k < 4; k++) note(k, {t_slow, t_mid, t_lcd, t_fast}[k], tick_m[k]);
    note(4, $countones({t_slow, t_mid, t_lcd, t_fast}) > 1, 0);
    note(5, osc_en, osc_m);
    note(6, flags, flag_m);
    note(7, drv, drv_m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seen;
    for (int c = 0; c < 8; c++) mis[c] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ticks", {t_slow, t_mid, t_lcd, t_fast}, 0);
    chk("R1 flags", flags, 0);
    chk("R1 drive", drv, 1);
    chk("R1 osc_en", osc_en, 1);
    rst_n = 1'b1;

    // long run across the whole strong-drive interval, middle flag disabled
    repeat (122900) step();
    chk("R10 weak drive", drv, 0);
    chk("R8 disabled flag", flags[1], 0);
    chk("R8 fast flag", flags[0], 1);
    chk("R8 slow flag", flags[2], 1);

    // R9: clear in the same cycle as a fast tick
    while (t_fast !== 1'b1) step();
    irq_clr = 3'b001;
    step();
    irq_clr = 3'b000;
    chk("R9 clear beats set", flags[0], 0);
    step();
    chk("R9 stays clear", flags[0], 0);
    while (t_fast !== 1'b1) step();
    step();
    chk("R9 set again after clear", flags[0], 1);

    // R7: stop and resume the oscillator
    osc_stop = 1'b1;
    step();
    chk("R7 osc off", osc_en, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if ({t_slow, t_mid, t_lcd, t_fast} != 0) seen++;
    end
    chk("R7 no ticks while off", seen, 0);
    osc_stop = 1'b0;
    step();
    chk("R7 osc on", osc_en, 1);
    repeat (300) step();

    // per-category results of the cycle-by-cycle comparison, walked from the table
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (mis[k] != 0) begin
        errors++;
        $display("FAIL %s tick bit %0d: actual %0d expected %0d", TAP_TAG[k], TAP_BIT[k],
                 mis_act[k], mis_exp[k]);
      end
    end
    chk("R6 exclusive ticks", mis[4] == 0 ? 0 : mis_act[4], 0);
    chk("R7 osc_en trace", mis[5] == 0 ? 0 : mis_act[5], mis[5] == 0 ? 0 : mis_exp[5]);
    chk("R8 flag trace", mis[6] == 0 ? 0 : mis_act[6], mis[6] == 0 ? 0 : mis_exp[6]);
    chk("R10 drive trace", mis[7] == 0 ? 0 : mis_act[7], mis[7] == 0 ? 0 : mis_exp[7]);
    chk("R6 mismatch count", mis[4], 0);

    // R1/R10: a new reset restores strong drive and clears flags
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 drive after re-reset", drv, 1);
    chk("R1 flags after re-reset", flags, 0);
    finish_run();
  end

endmodule